// File: doc/BRIEF.md
# Interrupt Driveback Request Generator

This block sits on the peripheral side of a shared bus. It watches a set of local interrupt lines, and a mask selects which of them the device owns. When the level of any owned line changes, the block asks the bus arbiter for a high-priority slot. It signals this on an active-low request line with a coded pattern: low for one clock, high for one clock, then low and held.

Once the arbiter answers on the active-low grant line, the block takes a snapshot of a 32-bit status word. It writes that word to a programmable I/O address over a simple single-beat bus with valid and ready. It then releases the request.

Each message restates the levels of every owned channel and marks all of them as enabled. The receiver therefore never depends on earlier messages for channels that did not change. A change that arrives while a message is in flight is remembered and produces one further message.

Top module: `irq_dbk_gen`

## Requirements
- R1: After reset `req_n` is 1 and `wr_valid` is 0, and no request starts until an owned line changes level.
- R2: A message starts by driving `req_n` low for exactly one clock and then high for exactly one clock. It then drives `req_n` low and holds it low until a clock edge at which `gnt_n` is 0.
- R3: At the clock edge at which `gnt_n` is seen 0 during the held phase, the write starts in the next cycle. `wr_valid` is 1 and `wr_addr` equals the value of `dbk_addr` at the grant edge. Address and data stay constant until the cycle in which `wr_ready` is 1. `req_n` stays low during the write and returns to 1 in the cycle after the handshake.
- R4: Bit n of `wr_data` (n = 0..15) carries the level of `irq_in[n]` at the grant edge for owned channels.
- R5: Bit 16+n of `wr_data` is 0 (enabled) for every channel whose `own_mask[n]` is 1. For every channel outside the mask it is 1, and bit n of such a channel is 0.
- R6: Both a rising and a falling level on an owned line each cause a message.
- R7: An owned-level change seen at the grant edge or later causes exactly one further message after the current one. Changes seen before the grant edge are covered by the snapshot and cause no extra message.
- R8: `gnt_n` low has no effect outside the held request phase. It is ignored both in idle and during the first two request clocks.
- R9: Level changes on lines outside `own_mask` do not start a message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NCH | Local interrupt levels |
| own_mask | input | NCH | 1 = channel is controlled by this device |
| dbk_addr | input | ADDR_W | I/O address that messages are written to |
| gnt_n | input | 1 | Active-low bus grant |
| wr_ready | input | 1 | Write accepted by the bus |
| req_n | output | 1 | Active-low bus request |
| wr_valid | output | 1 | Write beat valid |
| wr_addr | output | ADDR_W | Write address |
| wr_data | output | 32 | Status word: levels in [15:0], active-low enables in [31:16] |

## Verification
The bench drives `gnt_n` low in idle and during the first two request clocks. A design that honours an early grant would write too soon or skip the one-clock gap. Level changes are timed to land on the grant edge and during the write. A design that clears its pending flag too late would drop a message, and one that clears it too early would send a duplicate. Unowned lines toggle while the mask changes. A wrong enable or level packing, or a trigger from an unowned line, shows up as a data mismatch or a request the model does not expect. `wr_ready` is held off for random stretches to catch an address or data word that drifts during the wait.

// File: rtl/dbk_pkg.sv
package dbk_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PULSE = 3'd1,
        ST_GAP   = 3'd2,
        ST_HOLD  = 3'd3,
        ST_WRITE = 3'd4
    } dbk_state_e;

    localparam int WORD_W = 32;
    localparam int HALF_W = 16;
endpackage

// File: rtl/dbk_change_det.sv
module dbk_change_det #(
    parameter int NCH = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] irq_in,
    input  logic [NCH-1:0] own_mask,
    input  logic           clr,
    output logic           pend
);
    typedef struct packed {
        logic [NCH-1:0] prev;
        logic           pend;
    } det_t;

    det_t q, d;
    logic [NCH-1:0] lvl;
    logic           chg;

    always_comb begin
        lvl    = irq_in & own_mask;
        chg    = |(lvl ^ q.prev);
        d      = q;
        d.prev = lvl;
        d.pend = (q.pend && !clr) || chg;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pend = q.pend;

    // R7: a pending change survives until a snapshot consumes it
    a_r7_pend_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (q.pend && !clr) |=> q.pend);
endmodule

// File: rtl/dbk_seq.sv
module dbk_seq
    import dbk_pkg::*;
#(
    parameter int NCH    = 16,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pend,
    input  logic              gnt_n,
    input  logic              wr_ready,
    input  logic [NCH-1:0]    irq_in,
    input  logic [NCH-1:0]    own_mask,
    input  logic [ADDR_W-1:0] dbk_addr,
    output logic              take,
    output logic              req_n,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data
);
    typedef struct packed {
        dbk_state_e        st;
        logic [WORD_W-1:0] word;
        logic [ADDR_W-1:0] addr;
    } seq_t;

    seq_t q, d;
    logic [WORD_W-1:0] word_now;

    always_comb begin
        word_now = '0;
        word_now[WORD_W-1:HALF_W] = '1;
        for (int i = 0; i < NCH; i++) begin
            word_now[i]          = irq_in[i] & own_mask[i];
            word_now[HALF_W + i] = ~own_mask[i];
        end
    end

    always_comb begin
        d    = q;
        take = 1'b0;
        case (q.st)
            ST_IDLE:  if (pend) d.st = ST_PULSE;
            ST_PULSE: d.st = ST_GAP;
            ST_GAP:   d.st = ST_HOLD;
            ST_HOLD: begin
                if (!gnt_n) begin
                    take   = 1'b1;
                    d.st   = ST_WRITE;
                    d.word = word_now;
                    d.addr = dbk_addr;
                end
            end
            ST_WRITE: if (wr_ready) d.st = ST_IDLE;
            default:  d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, word: '0, addr: '0};
        else        q <= d;
    end

    assign req_n    = !(q.st == ST_PULSE || q.st == ST_HOLD || q.st == ST_WRITE);
    assign wr_valid = (q.st == ST_WRITE);
    assign wr_addr  = q.addr;
    assign wr_data  = q.word;

    // R2: the one-clock pulse is always followed by a released clock
    a_r2_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_PULSE) |=> req_n);
    // R3: request stays low for the whole write
    a_r3_req_during_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> !req_n);
    // R3: beat stays stable while stalled
    a_r3_beat_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));
    // R5: a level bit may be set only where the enable is active
    a_r5_level_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> ((wr_data[HALF_W-1:0] & wr_data[WORD_W-1:HALF_W]) == '0));
    // R8: a write only ever follows a held request
    a_r8_write_after_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_valid) |-> $past(q.st == ST_HOLD));
endmodule

// File: rtl/irq_dbk_gen.sv
module irq_dbk_gen #(
    parameter int NCH    = 16,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    irq_in,
    input  logic [NCH-1:0]    own_mask,
    input  logic [ADDR_W-1:0] dbk_addr,
    input  logic              gnt_n,
    input  logic              wr_ready,
    output logic              req_n,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [31:0]       wr_data
);
    logic pend;
    logic take;

    dbk_change_det #(.NCH(NCH)) u_det (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_in   (irq_in),
        .own_mask (own_mask),
        .clr      (take),
        .pend     (pend)
    );

    dbk_seq #(.NCH(NCH), .ADDR_W(ADDR_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend     (pend),
        .gnt_n    (gnt_n),
        .wr_ready (wr_ready),
        .irq_in   (irq_in),
        .own_mask (own_mask),
        .dbk_addr (dbk_addr),
        .take     (take),
        .req_n    (req_n),
        .wr_valid (wr_valid),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data)
    );

    // R1: no write can be under way in the first cycle after reset
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (req_n && !wr_valid));
endmodule

// File: tb/tb_irq_dbk_gen.sv
`timescale 1ns/1ps
module tb_irq_dbk_gen;
    localparam int NCH = 16;
    localparam int AW  = 32;

    logic          clk = 0;
    logic          rst_n = 0;
    logic [15:0]   irq_in = '0;
    logic [15:0]   own_mask = 16'h0F0F;
    logic [31:0]   dbk_addr = 32'h0000_0E80;
    logic          gnt_n = 1;
    logic          wr_ready = 0;
    logic          req_n, wr_valid;
    logic [31:0]   wr_addr, wr_data;

    irq_dbk_gen #(.NCH(NCH), .ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .own_mask(own_mask),
        .dbk_addr(dbk_addr), .gnt_n(gnt_n), .wr_ready(wr_ready),
        .req_n(req_n), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    always #5 clk = ~clk;

    int checks = 0, errors = 0, cycles = 0, msgs = 0;
    bit done = 0;

    // behavioural reference: phase 0 idle, 1 pulse, 2 gap, 3 hold, 4 write
    int          mph = 0;
    bit          mpend = 0;
    logic [15:0] mprev = '0;
    logic [31:0] mword = '0, maddr = '0;

    always @(posedge clk) begin
        logic [15:0] lv;
        bit chg, took;
        cycles++;
        if (!rst_n) begin
            mph = 0; mpend = 0; mprev = '0;
        end else begin
            lv   = irq_in & own_mask;
            chg  = (lv != mprev);
            took = 0;
            if (mph == 0) begin
                if (mpend) mph = 1;
            end else if (mph == 1) mph = 2;
            else if (mph == 2) mph = 3;
            else if (mph == 3) begin
                if (!gnt_n) begin
                    took  = 1;
                    mph   = 4;
                    mword = {~own_mask, lv};
                    maddr = dbk_addr;
                end
            end else if (mph == 4) begin
                if (wr_ready) begin mph = 0; msgs++; end
            end
            mpend = (mpend && !took) || chg;
            mprev = lv;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R1 R2 R8 req_n", {31'd0, req_n}, {31'd0, !(mph == 1 || mph == 3 || mph == 4)});
            chk("R3 R8 R9 wr_valid", {31'd0, wr_valid}, {31'd0, mph == 4});
            if (mph == 4) begin
                chk("R3 wr_addr", wr_addr, maddr);
                chk("R4 R6 R7 levels", {16'd0, wr_data[15:0]}, {16'd0, mword[15:0]});
                chk("R5 enables", {16'd0, wr_data[31:16]}, {16'd0, mword[31:16]});
            end
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run;
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        step(4);
        rst_n = 1;
        // R1: quiet with no change; R8: grant in idle ignored
        gnt_n = 0;
        step(6);
        chk("R1 R8 idle req_n", {31'd0, req_n}, 32'd1);
        gnt_n = 1;
        // R9: unowned change only
        irq_in[4] = 1;
        step(6);
        chk("R9 no request", {31'd0, req_n}, 32'd1);
        // R6 rising, with early grant during pulse and gap (R8)
        irq_in[3] = 1;
        step(2);
        gnt_n = 0;
        step(2);
        gnt_n = 1;
        step(3);
        gnt_n = 0;
        step(1);
        gnt_n = 1;
        irq_in[8] = 1; // R7: change right after grant edge
        step(2);
        wr_ready = 1;
        step(1);
        wr_ready = 0;
        step(12);
        gnt_n = 0;
        step(2);
        gnt_n = 1;
        wr_ready = 1;
        step(3);
        // R6 falling
        irq_in[3] = 0;
        gnt_n = 0;
        step(10);
        chk("R6 R7 message count", msgs, 3);
        // random phase
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 14) == 0) irq_in[$urandom_range(0, 15)] ^= 1'b1;
            if ($urandom_range(0, 300) == 0) own_mask = 16'($urandom);
            if ($urandom_range(0, 50) == 0) dbk_addr = $urandom;
            gnt_n    = ($urandom_range(0, 3) != 0);
            wr_ready = ($urandom_range(0, 2) == 0);
            step(1);
        end
        gnt_n = 0; wr_ready = 1;
        step(20);
        finish_run();
    end

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end
endmodule